// File: doc/BRIEF.md
# Passive Smart-Card Character Sniffer

This block listens, without driving anything, to the reset, clock and data lines that run between a card reader and a smart card, and turns the traffic on them into a stream of events for a downstream formatter. The three line inputs are first brought into the system clock domain. Bit timing is then measured by counting rising edges of the resynchronised card clock. It makes no use of a local baud generator. The block does not know which side is transmitting. Each asynchronous character on the data line is reported the same way, whichever direction it travels.

For every character the block reports four things: the eight data bits, the parity bit, the line level at the middle of the start bit, and a flag that says whether the receiving side signalled an error during the guard time. All bits are passed on exactly as they appeared on the wire, so decoding the inverse convention and checking parity are left to software. Every change of the reset line is reported as an event of its own. While reset is low, the character receiver is held idle.

The half, full and one-and-a-half etu lengths are inputs, counted in card clock cycles. A separate block can therefore change them after a speed negotiation. The default ratio F/D = 372 corresponds to 186, 372 and 558.

Top module: `iso7816_sniffer`

## Requirements
- R1: Each of the three line inputs passes through two cascaded flip-flops. A reset-line change applied between clock edges therefore appears on `evt_valid` right after the third rising system-clock edge, and not after the second.
- R2: Bit timing advances only on rising edges of the resynchronised card clock, one count per edge. No sampling point falls on any other cycle.
- R3: The start-bit midpoint is sampled on the `etu_half`-th card-clock rising edge after the edge at which the data line was first seen low. That sample is reported on `evt_start_bit`, and a glitch that has already returned high gives 1.
- R4: The eight data bits and the parity bit are sampled at successive `etu_full` intervals after the start midpoint. The first bit received goes to `evt_data[0]` and the ninth to `evt_parity`, with no inversion or reordering.
- R5: The guard-time sample is taken `etu_one_half` card-clock edges after the parity sample, and `evt_err_sig` is 1 exactly when the line was low there. A character event has `evt_kind` = 0 and `evt_rst_level` = 1.
- R6: While the resynchronised reset line is low, the receiver is held idle and produces no character events. A character that is partly received when reset falls is discarded.
- R7: Every change of the resynchronised reset line produces one event with `evt_kind` = 1 and `evt_rst_level` equal to the new level. A reset event takes priority over a character in the same cycle.
- R8: After the guard-time sample, the receiver waits until the data line is seen high on a card-clock edge before it looks for the next start bit. A long error signal therefore yields exactly one character.
- R9: The three etu lengths are captured from the inputs when a start bit is detected. New values take effect from the next character onwards, including the default 186/372/558 set.
- R10: After the system reset, `evt_valid` is 0, and no event is produced until a line change occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sim_rst_in | input | 1 | Tapped card reset line, asynchronous |
| sim_clk_in | input | 1 | Tapped card clock line, asynchronous |
| sim_io_in | input | 1 | Tapped card data line, asynchronous |
| etu_half | input | CNT_W | Card-clock cycles in 0.5 etu |
| etu_full | input | CNT_W | Card-clock cycles in 1 etu |
| etu_one_half | input | CNT_W | Card-clock cycles in 1.5 etu |
| evt_valid | output | 1 | One-cycle pulse, event fields valid |
| evt_kind | output | 1 | 0 = character, 1 = reset-line change |
| evt_rst_level | output | 1 | New reset level; 1 for characters |
| evt_data | output | 8 | Character data bits, first received in bit 0 |
| evt_parity | output | 1 | Received parity bit |
| evt_start_bit | output | 1 | Line level at start-bit midpoint |
| evt_err_sig | output | 1 | Error signal seen in guard time |

## Verification
The assertions check four rules on every cycle. A reset event always matches a real change of the resynchronised reset line. No character event is ever produced while reset is low, and every character event carries a reset level of 1. The receiver goes idle one cycle after reset is seen low, and two sampling strobes never fall on adjacent cycles. Other behaviours can only be shown by the bench's scenarios: that the sampling points sit where the etu counts place them, and the bit order, the start-bit glitch report, the guard-time error flag, the wait for the line to go high after a long error signal, the etu change between characters, and the three-edge latency of the resynchroniser.

// File: rtl/sniff_pkg.sv
// Shared types for the passive smart-card sniffer.
// Assumes: nothing beyond the standard language.
package sniff_pkg;

    // Receiver sequence: disarmed, waiting for idle-high line, hunting for a start edge,
    // timing the start midpoint, sampling 9 bits, sampling the guard time.
    typedef enum logic [2:0] {
        RX_OFF    = 3'd0,
        RX_WAITHI = 3'd1,
        RX_HUNT   = 3'd2,
        RX_START  = 3'd3,
        RX_BITS   = 3'd4,
        RX_GUARD  = 3'd5
    } rx_state_e;

    // Number of bits sampled after the start bit (8 data + parity).
    localparam int FRAME_BITS = 9;

    // One received character as handed to the event stage.
    typedef struct packed {
        logic [7:0] data;
        logic       parity;
        logic       start_bit;
        logic       err_sig;
    } char_rec_t;

endpackage

// File: rtl/sniff_sync.sv
// Multi-bit resynchroniser: every bit runs through its own chain of STAGES flops.
// Assumes: the bits are independent, so no cross-bit coherence is required.
module sniff_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    genvar gb;
    generate
        for (gb = 0; gb < WIDTH; gb++) begin : g_bit
            logic [STAGES-1:0] chain_q;

            // Shift the asynchronous level through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= {STAGES{RST_VAL[gb]}};
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], async_in[gb]};
                end
            end

            assign sync_out[gb] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sniff_tick.sv
// Rising-edge detector: one-cycle pulse when the synchronised card clock goes 0 -> 1.
// Assumes: the card clock is at most a quarter of the system clock rate.
module sniff_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic tick
);

    logic level_d;

    // Remember the previous level of the card clock.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= level;
    end

    assign tick = level & ~level_d;

endmodule

// File: rtl/sniff_rst_watch.sv
// Reset-line watcher: flags every change of the synchronised card reset level.
// Assumes: the line is held low by the system reset state of the synchroniser.
module sniff_rst_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic change
);

    logic level_d;

    // Track the last seen reset-line level.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= level;
    end

    assign change = level ^ level_d;

endmodule

// File: rtl/sniff_char_rx.sv
// Character receiver timed by card-clock ticks. Once the line is first seen low,
// it samples the start midpoint after `half` ticks, then 9 bits `full` ticks apart,
// then the guard time `one_half` ticks after the last bit. After that it waits for
// the line to be seen high before it re-arms.
// Assumes: `tick` is a single-cycle pulse per card-clock rising edge; etu inputs stable
// at start-bit detection.
module sniff_char_rx
    import sniff_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_level,
    input  logic             tick,
    input  logic             io,
    input  logic [CNT_W-1:0] half,
    input  logic [CNT_W-1:0] full,
    input  logic [CNT_W-1:0] one_half,
    output logic             char_done,
    output char_rec_t        char_rec,
    output logic             busy,
    output logic             samp_stb
);

    localparam int IDX_W = $clog2(FRAME_BITS);

    rx_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] full_q;
    logic [CNT_W-1:0] oh_q;
    logic [IDX_W-1:0] idx_q;
    logic [FRAME_BITS-1:0] shreg_q;
    logic             start_q;
    logic             err_q;
    logic             timing;

    // A sampling point is due when a timed state sees its final tick.
    always_comb begin
        timing   = (state_q == RX_START) || (state_q == RX_BITS) || (state_q == RX_GUARD);
        samp_stb = timing && tick && (cnt_q <= CNT_W'(1));
    end

    // Receiver sequencing, counting and bit capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= RX_OFF;
            cnt_q     <= '0;
            full_q    <= '0;
            oh_q      <= '0;
            idx_q     <= '0;
            shreg_q   <= '0;
            start_q   <= 1'b0;
            err_q     <= 1'b0;
            char_done <= 1'b0;
        end else if (!rst_level) begin
            state_q   <= RX_OFF;
            char_done <= 1'b0;
        end else begin
            char_done <= 1'b0;
            case (state_q)
                RX_OFF: begin
                    state_q <= RX_WAITHI;
                end
                RX_WAITHI: begin
                    if (tick && io) state_q <= RX_HUNT;
                end
                RX_HUNT: begin
                    if (tick && !io) begin
                        cnt_q   <= half;
                        full_q  <= full;
                        oh_q    <= one_half;
                        state_q <= RX_START;
                    end
                end
                RX_START: begin
                    if (samp_stb) begin
                        start_q <= io;
                        cnt_q   <= full_q;
                        idx_q   <= '0;
                        state_q <= RX_BITS;
                    end else if (tick) begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                RX_BITS: begin
                    if (samp_stb) begin
                        shreg_q <= {io, shreg_q[FRAME_BITS-1:1]};
                        if (idx_q == IDX_W'(FRAME_BITS - 1)) begin
                            cnt_q   <= oh_q;
                            state_q <= RX_GUARD;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                            cnt_q <= full_q;
                        end
                    end else if (tick) begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                RX_GUARD: begin
                    if (samp_stb) begin
                        err_q     <= ~io;
                        char_done <= 1'b1;
                        state_q   <= RX_WAITHI;
                    end else if (tick) begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: state_q <= RX_OFF;
            endcase
        end
    end

    assign busy               = (state_q != RX_OFF);
    assign char_rec.data      = shreg_q[7:0];
    assign char_rec.parity    = shreg_q[8];
    assign char_rec.start_bit = start_q;
    assign char_rec.err_sig   = err_q;

endmodule

// File: rtl/iso7816_sniffer.sv
// Passive sniffer top: resynchronises the card reset, clock and data lines, times
// characters on card-clock edges and merges character and reset-change events into
// one registered event port. Reset-line events win over characters in the same cycle.
// Assumes: the card clock is slow against clk (at least 4 system cycles per period).
module iso7816_sniffer
    import sniff_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sim_rst_in,
    input  logic             sim_clk_in,
    input  logic             sim_io_in,
    input  logic [CNT_W-1:0] etu_half,
    input  logic [CNT_W-1:0] etu_full,
    input  logic [CNT_W-1:0] etu_one_half,
    output logic             evt_valid,
    output logic             evt_kind,
    output logic             evt_rst_level,
    output logic [7:0]       evt_data,
    output logic             evt_parity,
    output logic             evt_start_bit,
    output logic             evt_err_sig
);

    localparam int LINES = 3;
    // Bit order inside the synchronised vector: {io, clk, rst}; io idles high.
    localparam logic [LINES-1:0] LINE_RST_VAL = 3'b100;

    logic [LINES-1:0] lines_s;
    logic             rst_s;
    logic             clk_s;
    logic             io_s;
    logic             clk_tick;
    logic             rst_chg;
    logic             char_done;
    char_rec_t        char_rec;
    logic             rx_busy;
    logic             samp_stb;

    sniff_sync #(
        .WIDTH   (LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (LINE_RST_VAL)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sim_io_in, sim_clk_in, sim_rst_in}),
        .sync_out (lines_s)
    );

    assign rst_s = lines_s[0];
    assign clk_s = lines_s[1];
    assign io_s  = lines_s[2];

    sniff_tick u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .level (clk_s),
        .tick  (clk_tick)
    );

    sniff_rst_watch u_rstw (
        .clk    (clk),
        .rst_n  (rst_n),
        .level  (rst_s),
        .change (rst_chg)
    );

    sniff_char_rx #(
        .CNT_W (CNT_W)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_level (rst_s),
        .tick      (clk_tick),
        .io        (io_s),
        .half      (etu_half),
        .full      (etu_full),
        .one_half  (etu_one_half),
        .char_done (char_done),
        .char_rec  (char_rec),
        .busy      (rx_busy),
        .samp_stb  (samp_stb)
    );

    // Register the outgoing event, giving reset-line changes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid     <= 1'b0;
            evt_kind      <= 1'b0;
            evt_rst_level <= 1'b0;
            evt_data      <= '0;
            evt_parity    <= 1'b0;
            evt_start_bit <= 1'b0;
            evt_err_sig   <= 1'b0;
        end else if (rst_chg) begin
            evt_valid     <= 1'b1;
            evt_kind      <= 1'b1;
            evt_rst_level <= rst_s;
            evt_data      <= '0;
            evt_parity    <= 1'b0;
            evt_start_bit <= 1'b0;
            evt_err_sig   <= 1'b0;
        end else if (char_done) begin
            evt_valid     <= 1'b1;
            evt_kind      <= 1'b0;
            evt_rst_level <= 1'b1;
            evt_data      <= char_rec.data;
            evt_parity    <= char_rec.parity;
            evt_start_bit <= char_rec.start_bit;
            evt_err_sig   <= char_rec.err_sig;
        end else begin
            evt_valid     <= 1'b0;
        end
    end

endmodule

// File: rtl/iso7816_sniffer_chk.sv
// Property checker for the sniffer top, bound onto every instance.
// Assumes: access to the synchronised reset level and receiver strobes by name.
module iso7816_sniffer_chk (
    input logic clk,
    input logic rst_n,
    input logic rst_s,
    input logic rx_busy,
    input logic samp_stb,
    input logic evt_valid,
    input logic evt_kind,
    input logic evt_rst_level
);

    // R7: a reset event reports a genuine change of the synchronised line, and its new level.
    a_r7_rst_evt_real: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind) |-> (evt_rst_level == $past(rst_s)) && ($past(rst_s) != $past(rst_s, 2)));

    // R6: no character event leaves the block for a cycle where reset was low.
    a_r6_no_char_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_kind) |-> $past(rst_s));

    // R6: the receiver is idle one cycle after reset is seen low.
    a_r6_idle_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_s |=> !rx_busy);

    // R5: character events carry reset level 1.
    a_r5_char_level_high: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_kind) |-> evt_rst_level);

    // R2: sampling points fall on card-clock ticks, never on adjacent cycles.
    a_r2_stb_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        samp_stb |=> !samp_stb);

endmodule

bind iso7816_sniffer iso7816_sniffer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rst_s         (rst_s),
    .rx_busy       (rx_busy),
    .samp_stb      (samp_stb),
    .evt_valid     (evt_valid),
    .evt_kind      (evt_kind),
    .evt_rst_level (evt_rst_level)
);

// File: tb/iso7816_sniffer_test.sv
// Directed bench for the passive sniffer: one task per scenario, each checking its own events.
module iso7816_sniffer_test;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 12;
    localparam int MAX_EV     = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sim_rst_in = 1'b0;
    logic             sim_clk_in = 1'b0;
    logic             sim_io_in = 1'b1;
    logic [CNT_W-1:0] etu_half = 12'd4;
    logic [CNT_W-1:0] etu_full = 12'd8;
    logic [CNT_W-1:0] etu_one_half = 12'd12;
    logic             evt_valid, evt_kind, evt_rst_level, evt_parity, evt_start_bit, evt_err_sig;
    logic [7:0]       evt_data;

    int n_checks = 0;
    int n_errors = 0;

    // Captured event log.
    int       ev_n = 0;
    logic     ev_kind [MAX_EV];
    logic     ev_lvl  [MAX_EV];
    logic [7:0] ev_data [MAX_EV];
    logic     ev_par  [MAX_EV];
    logic     ev_st   [MAX_EV];
    logic     ev_err  [MAX_EV];

    iso7816_sniffer #(.CNT_W(CNT_W)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sim_rst_in    (sim_rst_in),
        .sim_clk_in    (sim_clk_in),
        .sim_io_in     (sim_io_in),
        .etu_half      (etu_half),
        .etu_full      (etu_full),
        .etu_one_half  (etu_one_half),
        .evt_valid     (evt_valid),
        .evt_kind      (evt_kind),
        .evt_rst_level (evt_rst_level),
        .evt_data      (evt_data),
        .evt_parity    (evt_parity),
        .evt_start_bit (evt_start_bit),
        .evt_err_sig   (evt_err_sig)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Card clock: period of 4 system cycles, edges offset from the system clock edges.
    initial begin
        #3;
        forever #(2*CLK_PERIOD) sim_clk_in = ~sim_clk_in;
    end

    // Event capture, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && evt_valid && ev_n < MAX_EV) begin
            ev_kind[ev_n] = evt_kind;
            ev_lvl[ev_n]  = evt_rst_level;
            ev_data[ev_n] = evt_data;
            ev_par[ev_n]  = evt_parity;
            ev_st[ev_n]   = evt_start_bit;
            ev_err[ev_n]  = evt_err_sig;
            ev_n = ev_n + 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_char(input string req, input int i, input int d, input int p,
                               input int st, input int er);
        chk(req, "char kind", int'(ev_kind[i]), 0);
        chk(req, "char rst level", int'(ev_lvl[i]), 1);
        chk(req, "char data", int'(ev_data[i]), d);
        chk(req, "char parity", int'(ev_par[i]), p);
        chk(req, "char start sample", int'(ev_st[i]), st);
        chk(req, "char error flag", int'(ev_err[i]), er);
    endtask

    // Drive one character with E card clocks per etu.
    task automatic send_char(input logic [7:0] d, input logic p, input int E,
                             input bit glitch, input bit err_sig, input int err_len);
        @(negedge sim_clk_in);
        sim_io_in = 1'b0;
        if (glitch) begin
            repeat (2) @(negedge sim_clk_in);
            sim_io_in = 1'b1;
            repeat (E-2) @(negedge sim_clk_in);
        end else begin
            repeat (E) @(negedge sim_clk_in);
        end
        for (int i = 0; i < 8; i++) begin
            sim_io_in = d[i];
            repeat (E) @(negedge sim_clk_in);
        end
        sim_io_in = p;
        repeat (E) @(negedge sim_clk_in);
        sim_io_in = 1'b1;
        if (err_sig) begin
            repeat (E/2) @(negedge sim_clk_in);
            sim_io_in = 1'b0;
            repeat (err_len) @(negedge sim_clk_in);
            sim_io_in = 1'b1;
        end
        repeat (3*E) @(negedge sim_clk_in);
    endtask

    task automatic set_etu(input int h);
        etu_half     = CNT_W'(h);
        etu_full     = CNT_W'(2*h);
        etu_one_half = CNT_W'(3*h);
    endtask

    // R10: reset state and quiet outputs.
    task automatic t_reset;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "evt_valid after reset", int'(evt_valid), 0);
        repeat (40) @(negedge clk);
        chk("R10", "no events while quiet", ev_n, 0);
    endtask

    // R1, R7: reset-line rise latency and content.
    task automatic t_rst_rise;
        ev_n = 0;
        @(negedge clk);
        sim_rst_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "no event after two edges", int'(evt_valid), 0);
        @(negedge clk);
        chk("R1", "event after third edge", int'(evt_valid), 1);
        chk("R7", "rise kind", int'(evt_kind), 1);
        chk("R7", "rise level", int'(evt_rst_level), 1);
        repeat (40) @(negedge clk);
        chk("R7", "single rise event", ev_n, 1);
    endtask

    // R3, R4, R5: plain characters with direct bit order.
    task automatic t_basic;
        ev_n = 0;
        set_etu(4);
        send_char(8'h3B, 1'b1, 8, 1'b0, 1'b0, 0);
        send_char(8'hA5, 1'b0, 8, 1'b0, 1'b0, 0);
        chk("R4", "two characters", ev_n, 2);
        expect_char("R4", 0, 8'h3B, 1, 0, 0);
        expect_char("R4", 1, 8'hA5, 0, 0, 0);
    endtask

    // R4: raw bits of an inverse-convention opener passed through unchanged.
    task automatic t_inverse_raw;
        ev_n = 0;
        send_char(8'h03, 1'b1, 8, 1'b0, 1'b0, 0);
        chk("R4", "one raw char", ev_n, 1);
        expect_char("R4", 0, 8'h03, 1, 0, 0);
    endtask

    // R5: error signal in the guard time.
    task automatic t_error;
        ev_n = 0;
        send_char(8'h5A, 1'b1, 8, 1'b0, 1'b1, 12);
        chk("R5", "one flagged char", ev_n, 1);
        expect_char("R5", 0, 8'h5A, 1, 0, 1);
    endtask

    // R8: long error low yields one char; next char is still decoded.
    task automatic t_wait_high;
        ev_n = 0;
        send_char(8'hC3, 1'b0, 8, 1'b0, 1'b1, 32);
        chk("R8", "single char after long low", ev_n, 1);
        if (ev_n >= 1) expect_char("R8", 0, 8'hC3, 0, 0, 1);
        send_char(8'h96, 1'b0, 8, 1'b0, 1'b0, 0);
        chk("R8", "next char decoded", ev_n, 2);
        if (ev_n >= 2) expect_char("R8", 1, 8'h96, 0, 0, 0);
    endtask

    // R3: short low glitch gives start sample 1.
    task automatic t_glitch;
        ev_n = 0;
        send_char(8'hFF, 1'b1, 8, 1'b1, 1'b0, 0);
        chk("R3", "glitch char count", ev_n, 1);
        expect_char("R3", 0, 8'hFF, 1, 1, 0);
    endtask

    // R9, R2: etu changes between characters, including the default set.
    task automatic t_etu_change;
        ev_n = 0;
        set_etu(3);
        send_char(8'h69, 1'b1, 6, 1'b0, 1'b0, 0);
        set_etu(186);
        send_char(8'h2D, 1'b0, 372, 1'b0, 1'b1, 558);
        set_etu(4);
        chk("R9", "chars over etu change", ev_n, 2);
        expect_char("R9", 0, 8'h69, 1, 0, 0);
        expect_char("R2", 1, 8'h2D, 0, 0, 1);
    endtask

    // R6, R7: reset drop mid-character discards it; reset low keeps receiver idle.
    task automatic t_rst_abort;
        ev_n = 0;
        @(negedge sim_clk_in);
        sim_io_in = 1'b0;
        repeat (24) @(negedge sim_clk_in);
        @(negedge clk);
        sim_rst_in = 1'b0;
        repeat (8) @(negedge sim_clk_in);
        sim_io_in = 1'b1;
        repeat (120) @(negedge sim_clk_in);
        chk("R6", "only reset event after abort", ev_n, 1);
        chk("R7", "fall kind", int'(ev_kind[0]), 1);
        chk("R7", "fall level", int'(ev_lvl[0]), 0);
        send_char(8'h11, 1'b0, 8, 1'b0, 1'b0, 0);
        chk("R6", "no char while reset low", ev_n, 1);
        @(negedge clk);
        sim_rst_in = 1'b1;
        repeat (10) @(negedge sim_clk_in);
        send_char(8'h7E, 1'b0, 8, 1'b0, 1'b0, 0);
        chk("R6", "rise then char", ev_n, 3);
        chk("R7", "second rise level", int'(ev_lvl[1]), 1);
        expect_char("R6", 2, 8'h7E, 0, 0, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 190000);
        n_errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        t_reset();
        t_rst_rise();
        repeat (10) @(negedge sim_clk_in);
        t_basic();
        t_inverse_raw();
        t_error();
        t_wait_high();
        t_glitch();
        t_etu_change();
        t_rst_abort();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule